// File: doc/BRIEF.md
# Capacitive Sense Conversion Controller

This block is the digital sequencer that sits in front of an external capacitance-to-digital converter. Software programs it through a small register write port. It picks the event that launches a conversion: a software start, one of four timer overflow pulses, or free-running operation. It issues a start pulse to the converter, takes back a done pulse with a raw result word, masks that word to the selected resolution, and sums a group of results to produce an average. The averaged value and the channel it came from are held at the outputs.

In free-running scan mode the block walks an input multiplexer from a low channel to a high channel and then wraps. Each stored average is compared against a 16-bit threshold. A compare flag is raised when the value moves from not-above to above the threshold. Both the completion flag and the compare flag can drive an interrupt line, each through its own enable. While the enable bit is 0 the block sits idle and ignores every start source.

Top module: `capsense_ctrl`

## Requirements
- R1: While the enable bit (address 0, bit 0) is 0, no start source launches a conversion: `busy` stays 0 and `cv_start` never pulses.
- R2: With start mode 000 (address 0, bits 3:1) the block starts a conversion when address 1 is written with bit 2 set. `busy` and `cv_start` are both 1 in the cycle that follows the write edge.
- R3: The timer start modes map as follows: code 001 uses `tmr_ovf[0]`, 010 uses `tmr_ovf[2]`, 011 uses `tmr_ovf[1]` and 100 uses `tmr_ovf[3]`. A pulse on any other timer input does not start a conversion.
- R4: Start mode 101 never starts a conversion, whether from a timer pulse or a software write.
- R5: In start mode 110 a new conversion starts in the cycle after each completion, so `busy` is never low for more than one cycle while enabled.
- R6: In start mode 111 the channel advances from the low channel (address 3, bits 3:0) to the high channel (address 3, bits 7:4) and then wraps to the low channel. `result_ch` reports the channel of each stored result.
- R7: The resolution code (address 0, bits 5:4) keeps the low 12, 13, 14 or 16 bits of `cv_data` for codes 0, 1, 2 and 3.
- R8: The group-size code (address 0, bits 8:6) sets 1, 4, 8, 16, 32 or 64 conversions for codes 0 to 5. `result` is the masked sum divided by that count and rounded down. `done_flag` is set only when the last conversion of the group is stored.
- R9: `cmp_flag` is set when a stored result is greater than the threshold (address 2) and the previous stored result was not. A result equal to the threshold does not count as above it.
- R10: A write to address 1 clears `done_flag` when bit 0 is 0 and clears `cmp_flag` when bit 1 is 0. Writing 1 to either bit leaves that flag unchanged.
- R11: `irq` equals (`done_flag` AND the completion enable, address 0 bit 9) OR (`cmp_flag` AND the compare enable, address 0 bit 10).
- R12: A start event that arrives while `busy` is 1 is ignored, so a group always consists of exactly its configured number of conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| tmr_ovf | input | 4 | Timer overflow pulses, one per timer |
| cv_start | output | 1 | One-cycle start pulse to the converter |
| cv_res | output | 2 | Resolution code passed to the converter |
| cv_done | input | 1 | Converter done pulse |
| cv_data | input | 16 | Converter raw result, valid with `cv_done` |
| mux_sel | output | CH_W | Input multiplexer channel |
| busy | output | 1 | Conversion group in progress |
| result | output | 16 | Averaged result |
| result_ch | output | CH_W | Channel of the stored result |
| done_flag | output | 1 | Conversion-group complete flag |
| cmp_flag | output | 1 | Threshold crossing flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong group counter or shift shows up as a wrong `result` or a wrong number of `cv_start` pulses when `busy` next falls, which is one conversion group later. A corrupted crossing memory bit shows up as a missing or extra `cmp_flag` on the following stored result. A stuck scan pointer shows up in `result_ch` within one scan sweep. A start decoder that fires in the wrong mode shows up on `busy` in the cycle right after the offending timer pulse or write.

// File: rtl/capsense_pkg.sv
package capsense_pkg;

    localparam int DATA_W = 16;
    localparam int ACC_W  = DATA_W + 6;
    localparam int CNT_W  = 7;

    typedef enum logic [2:0] {
        SM_SOFT = 3'b000,
        SM_T0   = 3'b001,
        SM_T2   = 3'b010,
        SM_T1   = 3'b011,
        SM_T3   = 3'b100,
        SM_RSVD = 3'b101,
        SM_CONT = 3'b110,
        SM_SCAN = 3'b111
    } start_mode_e;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_FLAGS = 2'd1;
    localparam logic [1:0] A_THR   = 2'd2;
    localparam logic [1:0] A_SCAN  = 2'd3;

    function automatic logic [2:0] grp_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 3'd0;
            3'd1:    return 3'd2;
            3'd2:    return 3'd3;
            3'd3:    return 3'd4;
            3'd4:    return 3'd5;
            default: return 3'd6;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] res_mask(input logic [1:0] code);
        case (code)
            2'd0:    return 16'h0FFF;
            2'd1:    return 16'h1FFF;
            2'd2:    return 16'h3FFF;
            default: return 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/cs_trigger.sv
module cs_trigger
    import capsense_pkg::*;
(
    input  logic        en,
    input  logic        busy,
    input  start_mode_e mode,
    input  logic [3:0]  tmr_ovf,
    input  logic        sw_start,
    output logic        fire
);
    logic src;

    always_comb begin
        unique case (mode)
            SM_SOFT: src = sw_start;
            SM_T0:   src = tmr_ovf[0];
            SM_T2:   src = tmr_ovf[2];
            SM_T1:   src = tmr_ovf[1];
            SM_T3:   src = tmr_ovf[3];
            SM_RSVD: src = 1'b0;
            SM_CONT: src = 1'b1;
            SM_SCAN: src = 1'b1;
        endcase
        fire = en && !busy && src;
    end
endmodule

// File: rtl/cs_scan.sv
module cs_scan #(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scan_on,
    input  logic [CH_W-1:0] first_ch,
    input  logic [CH_W-1:0] last_ch,
    input  logic            advance,
    output logic [CH_W-1:0] cur_ch
);
    logic [CH_W-1:0] cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (!scan_on) begin
            cur_d = first_ch;
        end else if (advance) begin
            cur_d = (cur_q == last_ch) ? first_ch : cur_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign cur_ch = cur_q;
endmodule

// File: rtl/cs_accum.sv
module cs_accum
    import capsense_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add,
    input  logic [DATA_W-1:0] din,
    input  logic [2:0]        grp_code,
    output logic              last,
    output logic [DATA_W-1:0] avg
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } acc_t;

    acc_t a_d, a_q;
    logic [ACC_W-1:0] sum;
    logic [CNT_W-1:0] limit;
    logic [2:0]       sh;

    always_comb begin
        sh    = grp_shift(grp_code);
        limit = CNT_W'(1) << sh;
        sum   = a_q.acc + ACC_W'(din);
        last  = add && ((a_q.cnt + 1'b1) == limit);
        avg   = DATA_W'(sum >> sh);
        a_d   = a_q;
        if (clear || last) begin
            a_d.acc = '0;
            a_d.cnt = '0;
        end else if (add) begin
            a_d.acc = sum;
            a_d.cnt = a_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end
endmodule

// File: rtl/capsense_ctrl.sv
module capsense_ctrl
    import capsense_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic [3:0]        tmr_ovf,
    output logic              cv_start,
    output logic [1:0]        cv_res,
    input  logic              cv_done,
    input  logic [15:0]       cv_data,
    output logic [CH_W-1:0]   mux_sel,
    output logic              busy,
    output logic [15:0]       result,
    output logic [CH_W-1:0]   result_ch,
    output logic              done_flag,
    output logic              cmp_flag,
    output logic              irq
);
    typedef struct packed {
        logic              en;
        start_mode_e       mode;
        logic [1:0]        res;
        logic [2:0]        grp;
        logic              ie_done;
        logic              ie_cmp;
        logic [15:0]       thr;
        logic [CH_W-1:0]   ch_lo;
        logic [CH_W-1:0]   ch_hi;
        logic              busy;
        logic              kick;
        logic              done_f;
        logic              cmp_f;
        logic              prev_gt;
        logic [15:0]       result;
        logic [CH_W-1:0]   res_ch;
        logic [CH_W-1:0]   conv_ch;
    } state_t;

    state_t s_d, s_q;

    logic              sw_start, fire, acc_add, acc_clear, acc_last, gt;
    logic [DATA_W-1:0] acc_avg, masked;
    logic [CH_W-1:0]   cur_ch;
    logic [15:0]       thr_cur;

    assign sw_start  = cfg_we && (cfg_addr == A_FLAGS) && cfg_wdata[2];
    assign acc_add   = s_q.en && s_q.busy && cv_done;
    assign acc_clear = fire || !s_q.en;
    assign masked    = cv_data & res_mask(s_q.res);
    assign gt        = acc_avg > s_q.thr;

    cs_trigger u_trig (
        .en       (s_q.en),
        .busy     (s_q.busy),
        .mode     (s_q.mode),
        .tmr_ovf  (tmr_ovf),
        .sw_start (sw_start),
        .fire     (fire)
    );

    cs_accum u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (acc_clear),
        .add      (acc_add),
        .din      (masked),
        .grp_code (s_q.grp),
        .last     (acc_last),
        .avg      (acc_avg)
    );

    cs_scan #(.CH_W(CH_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_on  (s_q.mode == SM_SCAN),
        .first_ch (s_q.ch_lo),
        .last_ch  (s_q.ch_hi),
        .advance  (acc_add && acc_last),
        .cur_ch   (cur_ch)
    );

    always_comb begin
        s_d      = s_q;
        s_d.kick = 1'b0;

        if (cfg_we) begin
            unique case (cfg_addr)
                A_CTRL: begin
                    s_d.en      = cfg_wdata[0];
                    s_d.mode    = start_mode_e'(cfg_wdata[3:1]);
                    s_d.res     = cfg_wdata[5:4];
                    s_d.grp     = cfg_wdata[8:6];
                    s_d.ie_done = cfg_wdata[9];
                    s_d.ie_cmp  = cfg_wdata[10];
                end
                A_FLAGS: begin
                    s_d.done_f = s_q.done_f & cfg_wdata[0];
                    s_d.cmp_f  = s_q.cmp_f & cfg_wdata[1];
                end
                A_THR:  s_d.thr = cfg_wdata;
                A_SCAN: begin
                    s_d.ch_lo = cfg_wdata[CH_W-1:0];
                    s_d.ch_hi = cfg_wdata[2*CH_W-1:CH_W];
                end
            endcase
        end

        if (!s_q.en) begin
            s_d.busy = 1'b0;
        end else if (fire) begin
            s_d.busy    = 1'b1;
            s_d.kick    = 1'b1;
            s_d.conv_ch = cur_ch;
        end else if (acc_add) begin
            if (acc_last) begin
                s_d.busy    = 1'b0;
                s_d.result  = acc_avg;
                s_d.res_ch  = s_q.conv_ch;
                s_d.done_f  = 1'b1;
                s_d.prev_gt = gt;
                if (gt && !s_q.prev_gt) s_d.cmp_f = 1'b1;
            end else begin
                s_d.kick = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign thr_cur   = s_q.thr;
    assign cv_start  = s_q.kick;
    assign cv_res    = s_q.res;
    assign mux_sel   = cur_ch;
    assign busy      = s_q.busy;
    assign result    = s_q.result;
    assign result_ch = s_q.res_ch;
    assign done_flag = s_q.done_f;
    assign cmp_flag  = s_q.cmp_f;
    assign irq       = (s_q.done_f && s_q.ie_done) || (s_q.cmp_f && s_q.ie_cmp);
endmodule

// File: rtl/capsense_ctrl_chk.sv
module capsense_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cv_start,
    input logic        busy,
    input logic        done_flag,
    input logic        cmp_flag,
    input logic        irq,
    input logic [15:0] result,
    input logic [15:0] thr
);
    AST_KICK_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start |-> busy); // R2
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> !busy); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(result) || !busy)); // R8
    AST_CMP_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> (result > $past(thr))); // R9
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_flag || cmp_flag)); // R11
endmodule

bind capsense_ctrl capsense_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cv_start  (cv_start),
    .busy      (busy),
    .done_flag (done_flag),
    .cmp_flag  (cmp_flag),
    .irq       (irq),
    .result    (result),
    .thr       (thr_cur)
);

// File: tb/tb_capsense_ctrl.sv
module tb_capsense_ctrl;
    localparam int CH_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_addr = '0;
    logic [15:0]     cfg_wdata = '0;
    logic [3:0]      tmr_ovf = '0;
    logic            cv_start;
    logic [1:0]      cv_res;
    logic            cv_done = 1'b0;
    logic [15:0]     cv_data = '0;
    logic [CH_W-1:0] mux_sel;
    logic            busy;
    logic [15:0]     result;
    logic [CH_W-1:0] result_ch;
    logic            done_flag, cmp_flag, irq;

    int n_chk = 0, n_fail = 0;
    int nconv = 0, kicks = 0;
    int vals[4096];
    bit force_en = 1'b0;
    logic [15:0] force_val = '0;

    always #4 clk = ~clk;

    capsense_ctrl #(.CH_W(CH_W)) dut (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .tmr_ovf,
        .cv_start, .cv_res, .cv_done, .cv_data, .mux_sel, .busy,
        .result, .result_ch, .done_flag, .cmp_flag, .irq
    );

    // converter model: done two cycles after each start pulse
    initial begin
        forever begin
            if (rst_n && cv_start === 1'b1) begin
                kicks++;
                repeat (2) @(negedge clk);
                cv_data = force_en ? force_val : 16'($urandom);
                cv_done = 1'b1;
                @(negedge clk);
                vals[nconv % 4096] = int'(cv_data);
                nconv++;
                cv_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: act=timeout exp=finish");
        summary();
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        step();
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic set_ctrl(input bit en, input logic [2:0] mode, input logic [1:0] res,
                            input logic [2:0] grp, input bit ied, input bit iec);
        wr(2'd0, {5'b0, iec, ied, grp, res, mode, en});
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (busy && t < 3000) begin step(); t++; end
        if (t >= 3000) chk(req, 1, 0);
    endtask

    task automatic pulse(input logic [3:0] m);
        step();
        tmr_ovf = m;
        step();
        tmr_ovf = '0;
    endtask

    function automatic int mask_of(input int rc);
        case (rc)
            0: return 'h0FFF;
            1: return 'h1FFF;
            2: return 'h3FFF;
            default: return 'hFFFF;
        endcase
    endfunction

    function automatic int gsize(input int gc);
        case (gc)
            0: return 1;
            1: return 4;
            2: return 8;
            3: return 16;
            4: return 32;
            default: return 64;
        endcase
    endfunction

    function automatic int exp_avg(input int n, input int rc);
        int s = 0;
        for (int i = nconv - n; i < nconv; i++) s += vals[i % 4096] & mask_of(rc);
        return s / n;
    endfunction

    task automatic soft_group(input string req, input int rc, input int gc);
        int base = nconv;
        wr(2'd1, 16'h7);
        wait_idle(req);
        chk({req, " count"}, nconv - base, gsize(gc));
        chk({req, " result"}, int'(result), exp_avg(gsize(gc), rc));
    endtask

    task automatic forced(input logic [15:0] v);
        force_val = v;
        wr(2'd1, 16'h7);
        wait_idle("R9");
    endtask

    initial begin
        int base, k0, zr, maxz, got;
        void'($urandom(32'h5EED_C0DE));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // reset state
        chk("reset busy", int'(busy), 0);
        chk("reset cv_start", int'(cv_start), 0);
        chk("reset flags", int'({done_flag, cmp_flag, irq}), 0);
        chk("reset result", int'(result), 0);

        // R1: disabled block ignores all start sources
        set_ctrl(0, 3'b000, 2'd3, 3'd0, 0, 0);
        k0 = kicks;
        wr(2'd1, 16'h7);
        chk("R1 busy after sw start", int'(busy), 0);
        set_ctrl(0, 3'b001, 2'd3, 3'd0, 0, 0);
        pulse(4'hF);
        repeat (4) step();
        chk("R1 no start pulses", kicks - k0, 0);

        // R2: software start timing
        set_ctrl(1, 3'b000, 2'd3, 3'd0, 0, 0);
        step();
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 16'h7;
        step();
        cfg_we = 1'b0;
        chk("R2 busy next cycle", int'(busy), 1);
        chk("R2 cv_start next cycle", int'(cv_start), 1);
        wait_idle("R2");
        chk("R2 result", int'(result), exp_avg(1, 3));
        chk("R2 done flag", int'(done_flag), 1);

        // R3: timer mapping
        for (int m = 1; m <= 4; m++) begin
            int tsel;
            tsel = (m == 1) ? 0 : (m == 2) ? 2 : (m == 3) ? 1 : 3;
            set_ctrl(1, 3'(m), 2'd3, 3'd0, 0, 0);
            pulse(4'hF & ~(4'b1 << tsel));
            chk("R3 wrong timer ignored", int'(busy), 0);
            pulse(4'b1 << tsel);
            chk("R3 mapped timer starts", int'(busy), 1);
            wait_idle("R3");
        end

        // R4: reserved code
        set_ctrl(1, 3'b101, 2'd3, 3'd0, 0, 0);
        k0 = kicks;
        pulse(4'hF);
        wr(2'd1, 16'h7);
        repeat (3) step();
        chk("R4 reserved never starts", kicks - k0 + int'(busy), 0);

        // R7: resolution masks
        for (int rc = 0; rc < 4; rc++) begin
            set_ctrl(1, 3'b000, 2'(rc), 3'd0, 0, 0);
            soft_group("R7", rc, 0);
        end

        // R8: group sizes, done only after the last conversion
        for (int gc = 1; gc <= 5; gc++) begin
            set_ctrl(1, 3'b000, 2'd3, 3'(gc), 0, 0);
            wr(2'd1, 16'h0);
            base = nconv;
            wr(2'd1, 16'h4);
            while (nconv < base + 1) step();
            chk("R8 done low mid group", int'(done_flag), 0);
            chk("R8 busy mid group", int'(busy), 1);
            wait_idle("R8");
            chk("R8 count", nconv - base, gsize(gc));
            chk("R8 average", int'(result), exp_avg(gsize(gc), 3));
            chk("R8 done set", int'(done_flag), 1);
        end

        // R12: starts during busy ignored
        set_ctrl(1, 3'b000, 2'd3, 3'd1, 0, 0);
        base = nconv;
        wr(2'd1, 16'h7);
        step();
        wr(2'd1, 16'h7);
        pulse(4'hF);
        wr(2'd1, 16'h7);
        wait_idle("R12");
        chk("R12 group count", nconv - base, 4);
        chk("R12 result", int'(result), exp_avg(4, 3));

        // R9, R10, R11: threshold crossing and flags
        force_en = 1'b1;
        set_ctrl(1, 3'b000, 2'd3, 3'd0, 0, 0);
        wr(2'd2, 16'd1000);
        wr(2'd1, 16'h0);
        forced(16'd500);
        chk("R9 below", int'(cmp_flag), 0);
        forced(16'd1000);
        chk("R9 equal not above", int'(cmp_flag), 0);
        forced(16'd1001);
        chk("R9 crossing", int'(cmp_flag), 1);
        wr(2'd1, 16'h1);
        chk("R10 cmp cleared", int'(cmp_flag), 0);
        chk("R10 done kept", int'(done_flag), 1);
        forced(16'd2000);
        chk("R9 stays above no flag", int'(cmp_flag), 0);
        forced(16'd10);
        chk("R9 falls below", int'(cmp_flag), 0);
        forced(16'd3000);
        chk("R9 second crossing", int'(cmp_flag), 1);
        wr(2'd1, 16'h2);
        chk("R10 done cleared", int'(done_flag), 0);
        chk("R10 cmp kept", int'(cmp_flag), 1);
        set_ctrl(1, 3'b000, 2'd3, 3'd0, 1, 0);
        chk("R11 cmp masked", int'(irq), 0);
        set_ctrl(1, 3'b000, 2'd3, 3'd0, 0, 1);
        chk("R11 cmp enabled", int'(irq), 1);
        wr(2'd1, 16'h0);
        chk("R11 no flags", int'(irq), 0);
        forced(16'd5);
        set_ctrl(1, 3'b000, 2'd3, 3'd0, 1, 0);
        chk("R11 done enabled", int'(irq), 1);
        force_en = 1'b0;

        // R5: continuous mode restarts at once
        set_ctrl(1, 3'b110, 2'd3, 3'd0, 0, 0);
        base = nconv; zr = 0; maxz = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (!busy) begin zr++; if (zr > maxz) maxz = zr; end
            else zr = 0;
        end
        chk("R5 idle gap at most one", int'(maxz <= 1), 1);
        chk("R5 conversions run", int'(nconv - base >= 5), 1);
        set_ctrl(1, 3'b000, 2'd3, 3'd0, 0, 0);
        wait_idle("R5");

        // R6: auto-scan 3..5 with wrap
        wr(2'd3, 16'h0053);
        set_ctrl(1, 3'b111, 2'd3, 3'd0, 0, 0);
        got = 0;
        begin
            int seq[7] = '{3, 4, 5, 3, 4, 5, 3};
            bit pb = busy;
            int t = 0;
            while (got < 7 && t < 2000) begin
                step(); t++;
                if (pb && !busy) begin
                    chk("R6 scan channel", int'(result_ch), seq[got]);
                    got++;
                end
                pb = busy;
            end
        end
        chk("R6 sweep complete", got, 7);
        set_ctrl(1, 3'b000, 2'd3, 3'd0, 0, 0);
        wait_idle("R6");

        // random mix (R7, R8)
        for (int i = 0; i < 20; i++) begin
            int rc, gc;
            rc = int'($urandom % 4);
            gc = int'($urandom % 4);
            set_ctrl(1, 3'b000, 2'(rc), 3'(gc), 0, 0);
            soft_group("R8 random", rc, gc);
        end

        summary();
    end
endmodule